// File: doc/BRIEF.md
# Programmable Reference Frequency Divider

This block divides a reference clock by a ratio picked through a 5-bit code. It emits a one-cycle enable pulse once every N reference cycles, where N is the ratio the code decodes to. A phase comparison stage downstream can use that pulse as its comparison-frequency strobe. The ratio set is non-linear. The two upper code bits pick a mantissa family of 1, 5, 6 or 7. The three lower bits pick a power-of-two scale.

A new code is offered together with a one-cycle load strobe. It is held as a pending ratio and reaches the counter only at the next terminal count, so an output period is never cut short or stretched. In the 5x, 6x and 7x families, a scale index of zero has no valid ratio. Loading such a code leaves the pending ratio as it was and raises an illegal-code flag. The flag stays up until a legal code is loaded.

Top module: `refdiv_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `tick_o` and `illegal_o` are low. The ratio after reset is 2, so the first pulse comes in the second cycle after release.
- R2: Code family bits `ratio_code[4:3]` = 00 with scale index k = `ratio_code[2:0]` give a ratio of 2^(k+1), from 2 up to 256.
- R3: Family bits 01, 10 and 11 set mantissa 5, 6 and 7. A scale index k from 1 to 7 gives mantissa × 2^(k−1), up to 448.
- R4: `tick_o` is high for exactly one cycle at a time. Once a ratio N is in force, consecutive pulses are exactly N cycles apart.
- R5: A load of a code whose family bits are not 00 and whose scale index is 0 sets `illegal_o` from the next cycle on. It leaves the ratio in force and the pending ratio unchanged.
- R6: A load of any legal code clears `illegal_o` from the next cycle on.
- R7: A code loaded in some cycle sets the length of the periods that follow the first pulse after that cycle. The period that this first pulse ends keeps the earlier ratio.
- R8: The internal period counter always stays below the ratio in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_code | input | 5 | Ratio code: [4:3] family, [2:0] scale index |
| code_load | input | 1 | One-cycle strobe that offers `ratio_code` |
| tick_o | output | 1 | Divided enable pulse, one cycle wide |
| illegal_o | output | 1 | Last loaded code was illegal |

## Verification
The bench sweeps all 32 codes and measures the gap between pulses once each code has taken hold. It checks the 256 and 448 extremes and the three reserved codes. A decoder that mixed up the family or scale fields, or that was off by one in the shift, would show a wrong gap. Loads are also placed exactly in a pulse cycle and in the cycle just before one. A design that swapped ratios at once, instead of at the terminal count, would give a short or long period there. Illegal loads that come between legal ones show whether an illegal code wrongly replaces the pending ratio, or whether the flag fails to fall again.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  parameter int FAM_W  = 2;
  parameter int IDX_W  = 3;
  localparam int CODE_W  = FAM_W + IDX_W;
  localparam int MAX_MANT = 7;
  localparam int MAX_RATIO = MAX_MANT << ((1 << IDX_W) - 2);
  localparam int RATIO_W = $clog2(MAX_RATIO + 1);

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic [FAM_W-1:0] fam;
    logic [IDX_W-1:0] idx;
  } code_t;

  // Mantissa of a family: 1 for the plain powers of two, else 4 + family.
  function automatic logic [2:0] fam_mantissa(input logic [FAM_W-1:0] fam);
    logic [2:0] m;
    if (fam == '0) m = 3'd1;
    else           m = 3'(fam) + 3'd4;
    return m;
  endfunction

  function automatic logic code_legal(input code_t c);
    return !((c.fam != '0) && (c.idx == '0));
  endfunction

  // Decoded ratio; only meaningful for legal codes.
  function automatic ratio_t decode_ratio(input code_t c);
    ratio_t r;
    if (c.fam == '0)
      r = ratio_t'(2) << c.idx;
    else if (c.idx == '0)
      r = '0;
    else
      r = ratio_t'(fam_mantissa(c.fam)) << (c.idx - IDX_W'(1));
    return r;
  endfunction

  localparam ratio_t RESET_RATIO = ratio_t'(2);
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
(
  input  code_t  code,
  output ratio_t ratio,
  output logic   legal
);
  always_comb begin
    legal = code_legal(code);
    ratio = decode_ratio(code);
  end
endmodule

// File: rtl/refdiv_ratio_reg.sv
module refdiv_ratio_reg
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  logic   legal,
  input  ratio_t new_ratio,
  input  logic   tc,
  output ratio_t active_ratio,
  output ratio_t pending_ratio,
  output logic   illegal
);
  logic take_new;
  logic take_bad;

  assign take_new = load && legal;
  assign take_bad = load && !legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_ratio <= RESET_RATIO;
      active_ratio  <= RESET_RATIO;
      illegal       <= 1'b0;
    end else begin
      if (take_new) pending_ratio <= new_ratio;
      if (take_new)      illegal <= 1'b0;
      else if (take_bad) illegal <= 1'b1;
      if (tc) active_ratio <= pending_ratio;
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ratio_t ratio,
  output ratio_t cnt,
  output logic   tc
);
  assign tc = (cnt == ratio - ratio_t'(1));

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (tc) cnt <= '0;
    else         cnt <= cnt + ratio_t'(1);
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              code_load,
  output logic              tick_o,
  output logic              illegal_o
);
  code_t  code_s;
  ratio_t dec_ratio;
  logic   dec_legal;
  ratio_t active_ratio;
  ratio_t pending_ratio;
  ratio_t cnt;
  logic   tc;

  assign code_s = code_t'(ratio_code);

  refdiv_decode u_dec (
    .code  (code_s),
    .ratio (dec_ratio),
    .legal (dec_legal)
  );

  refdiv_ratio_reg u_reg (
    .clk           (clk),
    .rst           (rst),
    .load          (code_load),
    .legal         (dec_legal),
    .new_ratio     (dec_ratio),
    .tc            (tc),
    .active_ratio  (active_ratio),
    .pending_ratio (pending_ratio),
    .illegal       (illegal_o)
  );

  refdiv_counter u_cnt (
    .clk   (clk),
    .rst   (rst),
    .ratio (active_ratio),
    .cnt   (cnt),
    .tc    (tc)
  );

  assign tick_o = tc;
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] ratio_code,
  input logic              code_load,
  input logic              tick_o,
  input logic              illegal_o,
  input ratio_t            cnt,
  input ratio_t            active_ratio,
  input ratio_t            pending_ratio
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!tick_o && !illegal_o && active_ratio == RESET_RATIO));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    (code_load && !code_legal(code_t'(ratio_code))) |=> illegal_o);

  assert_pending_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (code_load && !code_legal(code_t'(ratio_code))) |=> $stable(pending_ratio));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (code_load && code_legal(code_t'(ratio_code))) |=> !illegal_o);

  assert_hold_mid_period_R7: assert property (@(posedge clk) disable iff (rst)
    !tick_o |=> $stable(active_ratio));

  assert_swap_at_terminal_R7: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (active_ratio == $past(pending_ratio)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt < active_ratio);
endmodule

bind refdiv_top refdiv_checker u_refdiv_checker (
  .clk           (clk),
  .rst           (rst),
  .ratio_code    (ratio_code),
  .code_load     (code_load),
  .tick_o        (tick_o),
  .illegal_o     (illegal_o),
  .cnt           (cnt),
  .active_ratio  (active_ratio),
  .pending_ratio (pending_ratio)
);

// File: tb/test_refdiv_top.sv
`timescale 1ns/1ps
module test_refdiv_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ratio_code = '0;
  logic       code_load = 1'b0;
  logic       tick_o;
  logic       illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model state
  int m_since, m_period, m_pend;
  bit m_ill;
  bit last_tick;

  always #2.5 clk = ~clk;

  refdiv_top i_refdiv_top (
    .clk(clk), .rst(rst), .ratio_code(ratio_code), .code_load(code_load),
    .tick_o(tick_o), .illegal_o(illegal_o)
  );

  function automatic bit b_legal(int code);
    return !((code >> 3) != 0 && (code & 7) == 0);
  endfunction

  function automatic int b_ratio(int code);
    int fam = code >> 3;
    int idx = code & 7;
    int r;
    if (fam == 0) begin
      r = 1;
      for (int i = 0; i <= idx; i++) r = r * 2;
    end else begin
      r = (fam == 1) ? 5 : (fam == 2) ? 6 : 7;
      for (int i = 1; i < idx; i++) r = r * 2;
    end
    return r;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic model_reset();
    m_since = 0; m_period = 2; m_pend = 2; m_ill = 0;
  endtask

  // Called at a negedge: check outputs, drive inputs, advance model, wait.
  task automatic step(bit ld, int code);
    bit exp_tick;
    exp_tick = (m_since == m_period - 1);
    last_tick = tick_o;
    check("R4/R7 tick timing", int'(tick_o), int'(exp_tick));
    check("R5/R6 illegal flag", int'(illegal_o), int'(m_ill));
    code_load  = ld;
    ratio_code = 5'(code);
    if (exp_tick) begin m_since = 0; m_period = m_pend; end
    else m_since++;
    if (ld) begin
      if (b_legal(code)) begin m_pend = b_ratio(code); m_ill = 0; end
      else m_ill = 1;
    end
    @(negedge clk);
  endtask

  // Load a code, then measure the first full period after it takes hold.
  task automatic measure(int code, int exp_gap, string req);
    int seen = 0;
    int gap = 0;
    step(1, code);
    while (seen < 2) begin
      step(0, 0);
      if (seen == 1) gap++;
      if (last_tick) seen++;
    end
    check(req, gap, exp_gap);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int prev;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 tick in reset", int'(tick_o), 0);
    check("R1 flag in reset", int'(illegal_o), 0);
    rst = 1'b0;
    model_reset();
    check("R1 first cycle tick", int'(tick_o), 0);
    for (int i = 0; i < 20; i++) step(0, 0);

    // Sweep every code; illegal ones keep the previous ratio (R5).
    prev = 2;
    for (int c = 0; c < 32; c++) begin
      if (b_legal(c)) begin
        measure(c, b_ratio(c), (c < 8) ? "R2 power-of-two ratio" : "R3 mantissa ratio");
        prev = b_ratio(c);
      end else begin
        measure(c, prev, "R5 illegal keeps ratio");
      end
    end

    // Legal code after illegal clears the flag (R6).
    measure(5'b01000, prev, "R5 illegal again");
    measure(5'b00001, 4, "R6 legal after illegal");

    // Load exactly on a pulse cycle and the cycle before one (R7).
    while (!(m_since == m_period - 1)) step(0, 0);
    step(1, 5'b01001);
    for (int i = 0; i < 30; i++) step(0, 0);
    while (!(m_since == m_period - 2)) step(0, 0);
    step(1, 5'b11010);
    for (int i = 0; i < 60; i++) step(0, 0);

    // Constrained random phase, fixed seed.
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 15);
      int c = $urandom_range(0, 31);
      if (r == 0 && c >= 8) c = c & 5'b11000;
      else if (r < 3) c = c & 5'b01011;
      step(r < 3, c);
    end

    // Mid-run reset returns to the ratio of 2 (R1).
    rst = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", int'(illegal_o), 0);
    rst = 1'b0;
    model_reset();
    for (int i = 0; i < 10; i++) step(0, 0);
    measure(5'b00000, 2, "R1 reset ratio");
    report();
  end
endmodule